// File: doc/BRIEF.md
# Execute-Group Redirect and Squash Generator

This block looks at one group of instructions as they leave the execute stage and decides whether fetch must be redirected. Each slot of the group arrives with its own flags: occupied, already squashed, branch outcome wrong, predicted taken, memory-order violation. Each slot also carries its sequence number, its PC and its resolved next PC. The block walks the slots in slot order and stops at the first empty slot, or once the number of functional units used reaches the execute width. A slot that was already squashed uses no unit and is passed over. The first live slot that shows a wrong branch or a memory-order violation supplies the one redirect allowed per group.

Branch evaluation and violation detection happen upstream. The block only chooses a cause and builds the outgoing packet. A branch redirect carries the sequence number, PC, next PC, a mispredict flag and a recomputed taken bit. A memory-order redirect carries only the sequence number and next PC. It also sends a one-cycle notice to the scheduler naming both the offending instruction and the load/store unit's violator. Two event counters record wrongly predicted taken branches and memory-order violations.

Top module: `exgrp_redirect`

## Requirements
- R1: While reset is asserted, and after it is released with no group, every packet output, the violation notice and both counters read zero.
- R2: The scan stops at the first slot whose occupied flag is 0, so a redirect cause in any later slot has no effect.
- R3: The scan stops once EXEC_W unsquashed slots have been examined (default EXEC_W=3 of ISSUE_W=4), so a cause in any later slot has no effect.
- R4: A slot marked squashed uses no functional unit and cannot cause a redirect, even if its mispredict or violation flag is set.
- R5: Only the first slot in slot order with a cause produces a redirect; causes in later slots of the same group are ignored.
- R6: Within one slot, a set mispredict flag takes priority over a set violation flag, and the redirect is a branch redirect.
- R7: A branch redirect presents sq_valid=1, sq_mispred=1, and the slot's sequence number, PC and next PC on sq_seq, sq_pc and sq_npc.
- R8: On a branch redirect, sq_taken is 1 exactly when the next PC differs from PC+4; sq_taken is 0 on every other packet.
- R9: A memory redirect presents sq_valid=1, sq_mispred=0, sq_taken=0, sq_pc=0 and the slot's sequence number and next PC. In the same cycle, viol_valid=1, viol_inst_seq is the slot's sequence number and viol_by_seq is violator_seq.
- R10: The packet and the notice appear in the cycle after the clock edge that samples grp_valid=1, and they last one cycle. A cycle whose grp_valid was 0 produces sq_valid=0 and viol_valid=0.
- R11: cnt_taken_wrong increments by one on each branch redirect whose slot had predicted-taken set, and on nothing else.
- R12: cnt_mem_viol increments by one on each memory redirect, and on nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_valid | input | 1 | A group is presented this cycle |
| slot_valid | input | ISSUE_W | Slot holds an instruction |
| slot_squashed | input | ISSUE_W | Slot instruction was already squashed |
| slot_mispred | input | ISSUE_W | Branch outcome in the slot was mispredicted |
| slot_pred_taken | input | ISSUE_W | Slot branch had been predicted taken |
| slot_viol | input | ISSUE_W | Load/store unit reports an order violation for the slot |
| slot_seq | input | ISSUE_W*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W |
| slot_pc | input | ISSUE_W*PC_W | PCs, slot i at bits i*PC_W |
| slot_npc | input | ISSUE_W*PC_W | Resolved next PCs, slot i at bits i*PC_W |
| violator_seq | input | SEQ_W | Sequence number of the violating instruction from the load/store unit |
| sq_valid | output | 1 | Squash packet valid |
| sq_seq | output | SEQ_W | Sequence number of the squashing instruction |
| sq_pc | output | PC_W | PC of the mispredicted branch, 0 for a memory redirect |
| sq_npc | output | PC_W | Next PC to fetch from |
| sq_mispred | output | 1 | Packet is a branch mispredict |
| sq_taken | output | 1 | Corrected branch direction |
| viol_valid | output | 1 | Violation notice to the scheduler |
| viol_inst_seq | output | SEQ_W | Instruction that exposed the violation |
| viol_by_seq | output | SEQ_W | Violating instruction |
| cnt_taken_wrong | output | CNT_W | Count of wrongly predicted taken branches |
| cnt_mem_viol | output | CNT_W | Count of memory-order violations |

## Verification
A wrong scan boundary or a wrong priority prefix in this block shows up one cycle after the group is presented. The packet then either names a different slot's sequence number and PC, or appears when no redirect should occur. A wrong cause selection shows up as a mismatch among sq_mispred, sq_pc and viol_valid in that same cycle. A counter enable on the wrong condition stays in the counter value, so a fault there is still visible at every later check. Directed groups put causes just past an empty slot, just past the unit limit, behind squashed slots and in pairs. Random groups then mix all flags.

// File: rtl/exgrp_pkg.sv
package exgrp_pkg;
  // Byte size of one instruction, used to rebuild the fall-through address
  localparam int unsigned INSTR_BYTES = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_MEM    = 2'd2
  } redir_cause_e;
endpackage

// File: rtl/exgrp_scan.sv
// Decides which slots of the group are examined, in slot order.
module exgrp_scan #(
  parameter int ISSUE_W = 4,
  parameter int EXEC_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ISSUE_W-1:0] slot_valid,
  input  logic [ISSUE_W-1:0] slot_squashed,
  output logic [ISSUE_W-1:0] scan_mask
);
  localparam int UW = $clog2(ISSUE_W + 1);

  always_comb begin
    logic          alive;
    logic [UW-1:0] used;
    alive     = 1'b1;
    used      = '0;
    scan_mask = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      if (alive && slot_valid[i] && (int'(used) < EXEC_W)) begin
        scan_mask[i] = 1'b1;
        if (!slot_squashed[i]) used = used + UW'(1);
      end else begin
        alive = 1'b0;
      end
    end
  end

  // R2: the examined slots form an unbroken run of occupied slots from slot 0
  for (genvar g = 0; g < ISSUE_W; g++) begin : g_chk
    assert_scan_occupied_R2: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mask[g] |-> slot_valid[g]);
    if (g > 0) begin : g_prefix
      assert_scan_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mask[g] |-> scan_mask[g-1]);
    end
  end

  // R3: never more unsquashed slots examined than functional units
  assert_unit_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(scan_mask & ~slot_squashed) <= EXEC_W);
endmodule

// File: rtl/exgrp_pick.sv
// Picks the first live slot with a redirect cause and muxes its fields.
module exgrp_pick import exgrp_pkg::*; #(
  parameter int ISSUE_W = 4,
  parameter int SEQ_W   = 8,
  parameter int PC_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ISSUE_W-1:0]         scan_mask,
  input  logic [ISSUE_W-1:0]         slot_squashed,
  input  logic [ISSUE_W-1:0]         slot_mispred,
  input  logic [ISSUE_W-1:0]         slot_pred_taken,
  input  logic [ISSUE_W-1:0]         slot_viol,
  input  logic [ISSUE_W*SEQ_W-1:0]   slot_seq,
  input  logic [ISSUE_W*PC_W-1:0]    slot_pc,
  input  logic [ISSUE_W*PC_W-1:0]    slot_npc,
  output logic                       win_hit,
  output redir_cause_e               win_cause,
  output logic                       win_pred_taken,
  output logic [SEQ_W-1:0]           win_seq,
  output logic [PC_W-1:0]            win_pc,
  output logic [PC_W-1:0]            win_npc
);
  logic [ISSUE_W-1:0] cand;
  logic [ISSUE_W-1:0] seen_before;
  logic [ISSUE_W-1:0] win;

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_slot
    assign cand[g] = scan_mask[g] & ~slot_squashed[g] & (slot_mispred[g] | slot_viol[g]);
    if (g == 0) begin : g_first
      assign seen_before[g] = 1'b0;
    end else begin : g_rest
      assign seen_before[g] = seen_before[g-1] | cand[g-1];
    end
    assign win[g] = cand[g] & ~seen_before[g];
  end

  always_comb begin
    logic mp_sel;
    mp_sel         = 1'b0;
    win_pred_taken = 1'b0;
    win_seq        = '0;
    win_pc         = '0;
    win_npc        = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      mp_sel         = mp_sel | (win[i] & slot_mispred[i]);
      win_pred_taken = win_pred_taken | (win[i] & slot_pred_taken[i]);
      win_seq        = win_seq | (slot_seq[i*SEQ_W +: SEQ_W] & {SEQ_W{win[i]}});
      win_pc         = win_pc  | (slot_pc[i*PC_W +: PC_W]    & {PC_W{win[i]}});
      win_npc        = win_npc | (slot_npc[i*PC_W +: PC_W]   & {PC_W{win[i]}});
    end
    win_hit = |win;
    if (!win_hit)    win_cause = CAUSE_NONE;
    else if (mp_sel) win_cause = CAUSE_BRANCH;
    else             win_cause = CAUSE_MEM;
  end

  // R5: at most one winning slot per group
  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  for (genvar g = 0; g < ISSUE_W; g++) begin : g_chk
    // R4: a squashed or unexamined slot never wins
    assert_winner_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win[g] |-> (scan_mask[g] && !slot_squashed[g]));
    // R6: a winning slot with a mispredict always yields a branch cause
    assert_branch_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win[g] && slot_mispred[g]) |-> (win_cause == CAUSE_BRANCH));
  end
endmodule

// File: rtl/exgrp_squash_reg.sv
// Builds and registers the squash packet and the scheduler notice.
module exgrp_squash_reg import exgrp_pkg::*; #(
  parameter int SEQ_W = 8,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_valid,
  input  logic             win_hit,
  input  redir_cause_e     win_cause,
  input  logic [SEQ_W-1:0] win_seq,
  input  logic [PC_W-1:0]  win_pc,
  input  logic [PC_W-1:0]  win_npc,
  input  logic [SEQ_W-1:0] violator_seq,
  output logic             sq_valid,
  output logic [SEQ_W-1:0] sq_seq,
  output logic [PC_W-1:0]  sq_pc,
  output logic [PC_W-1:0]  sq_npc,
  output logic             sq_mispred,
  output logic             sq_taken,
  output logic             viol_valid,
  output logic [SEQ_W-1:0] viol_inst_seq,
  output logic [SEQ_W-1:0] viol_by_seq
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic             fire, is_br, is_mem;
  logic             nx_valid, nx_mispred, nx_taken, nx_vvalid;
  logic [SEQ_W-1:0] nx_seq, nx_vseq, nx_vby;
  logic [PC_W-1:0]  nx_pc, nx_npc;

  always_comb begin
    fire       = grp_valid & win_hit;
    is_br      = fire & (win_cause == CAUSE_BRANCH);
    is_mem     = fire & (win_cause == CAUSE_MEM);
    nx_valid   = fire;
    nx_seq     = fire  ? win_seq : '0;
    nx_npc     = fire  ? win_npc : '0;
    nx_pc      = is_br ? win_pc  : '0;
    nx_mispred = is_br;
    nx_taken   = is_br & (win_npc != (win_pc + STEP));
    nx_vvalid  = is_mem;
    nx_vseq    = is_mem ? win_seq      : '0;
    nx_vby     = is_mem ? violator_seq : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_valid      <= 1'b0;
      sq_seq        <= '0;
      sq_pc         <= '0;
      sq_npc        <= '0;
      sq_mispred    <= 1'b0;
      sq_taken      <= 1'b0;
      viol_valid    <= 1'b0;
      viol_inst_seq <= '0;
      viol_by_seq   <= '0;
    end else begin
      sq_valid      <= nx_valid;
      sq_seq        <= nx_seq;
      sq_pc         <= nx_pc;
      sq_npc        <= nx_npc;
      sq_mispred    <= nx_mispred;
      sq_taken      <= nx_taken;
      viol_valid    <= nx_vvalid;
      viol_inst_seq <= nx_vseq;
      viol_by_seq   <= nx_vby;
    end
  end

  // R10: no group sampled means no packet in the following cycle
  assert_no_group_no_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> (!sq_valid && !viol_valid));
  // R9: the notice only accompanies a memory-type packet
  assert_notice_is_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (sq_valid && !sq_mispred && !sq_taken && sq_pc == '0));
  // R8: a taken correction only rides on a branch packet
  assert_taken_on_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_taken |-> (sq_valid && sq_mispred));
  // R7: a mispredict flag never appears without a valid packet
  assert_mispred_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_mispred |-> sq_valid);
endmodule

// File: rtl/exgrp_counter.sv
// Event counter with an explicit clock enable, wrapping at its width.
module exgrp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nx;

  always_comb count_nx = count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count_nx;
  end

  // R11: counter moves by exactly one on an event and holds otherwise
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (count == $past(count) + CNT_W'(1)));
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/exgrp_redirect.sv
module exgrp_redirect import exgrp_pkg::*; #(
  parameter int ISSUE_W = 4,
  parameter int EXEC_W  = 3,
  parameter int SEQ_W   = 8,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grp_valid,
  input  logic [ISSUE_W-1:0]       slot_valid,
  input  logic [ISSUE_W-1:0]       slot_squashed,
  input  logic [ISSUE_W-1:0]       slot_mispred,
  input  logic [ISSUE_W-1:0]       slot_pred_taken,
  input  logic [ISSUE_W-1:0]       slot_viol,
  input  logic [ISSUE_W*SEQ_W-1:0] slot_seq,
  input  logic [ISSUE_W*PC_W-1:0]  slot_pc,
  input  logic [ISSUE_W*PC_W-1:0]  slot_npc,
  input  logic [SEQ_W-1:0]         violator_seq,
  output logic                     sq_valid,
  output logic [SEQ_W-1:0]         sq_seq,
  output logic [PC_W-1:0]          sq_pc,
  output logic [PC_W-1:0]          sq_npc,
  output logic                     sq_mispred,
  output logic                     sq_taken,
  output logic                     viol_valid,
  output logic [SEQ_W-1:0]         viol_inst_seq,
  output logic [SEQ_W-1:0]         viol_by_seq,
  output logic [CNT_W-1:0]         cnt_taken_wrong,
  output logic [CNT_W-1:0]         cnt_mem_viol
);
  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  logic [ISSUE_W-1:0] scan_mask;
  logic               win_hit, win_pred_taken;
  redir_cause_e       win_cause;
  logic [SEQ_W-1:0]   win_seq;
  logic [PC_W-1:0]    win_pc, win_npc;
  logic               inc_taken_wrong, inc_mem_viol;

  exgrp_scan #(.ISSUE_W(ISSUE_W), .EXEC_W(EXEC_W)) u_scan (
    .clk(clk), .rst_n(rst_ns),
    .slot_valid(slot_valid), .slot_squashed(slot_squashed),
    .scan_mask(scan_mask)
  );

  exgrp_pick #(.ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_pick (
    .clk(clk), .rst_n(rst_ns),
    .scan_mask(scan_mask), .slot_squashed(slot_squashed),
    .slot_mispred(slot_mispred), .slot_pred_taken(slot_pred_taken),
    .slot_viol(slot_viol), .slot_seq(slot_seq), .slot_pc(slot_pc),
    .slot_npc(slot_npc),
    .win_hit(win_hit), .win_cause(win_cause), .win_pred_taken(win_pred_taken),
    .win_seq(win_seq), .win_pc(win_pc), .win_npc(win_npc)
  );

  exgrp_squash_reg #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_pkt (
    .clk(clk), .rst_n(rst_ns),
    .grp_valid(grp_valid), .win_hit(win_hit), .win_cause(win_cause),
    .win_seq(win_seq), .win_pc(win_pc), .win_npc(win_npc),
    .violator_seq(violator_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_npc(sq_npc),
    .sq_mispred(sq_mispred), .sq_taken(sq_taken),
    .viol_valid(viol_valid), .viol_inst_seq(viol_inst_seq),
    .viol_by_seq(viol_by_seq)
  );

  always_comb begin
    inc_taken_wrong = grp_valid & win_hit & (win_cause == CAUSE_BRANCH) & win_pred_taken;
    inc_mem_viol    = grp_valid & win_hit & (win_cause == CAUSE_MEM);
  end

  exgrp_counter #(.CNT_W(CNT_W)) u_cnt_taken (
    .clk(clk), .rst_n(rst_ns), .inc(inc_taken_wrong), .count(cnt_taken_wrong)
  );

  exgrp_counter #(.CNT_W(CNT_W)) u_cnt_mem (
    .clk(clk), .rst_n(rst_ns), .inc(inc_mem_viol), .count(cnt_mem_viol)
  );

  // R12: the memory counter advances exactly when a notice is produced
  assert_mem_count_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    viol_valid |-> (cnt_mem_viol == $past(cnt_mem_viol) + CNT_W'(1)));
endmodule

// File: tb/tb_exgrp_redirect.sv
module tb_exgrp_redirect;
  localparam int IW = 4, EW = 3, SW = 8, PW = 32, CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic grp_valid;
  logic [IW-1:0] slot_valid, slot_squashed, slot_mispred, slot_pred_taken, slot_viol;
  logic [IW*SW-1:0] slot_seq;
  logic [IW*PW-1:0] slot_pc, slot_npc;
  logic [SW-1:0] violator_seq;
  logic sq_valid, sq_mispred, sq_taken, viol_valid;
  logic [SW-1:0] sq_seq, viol_inst_seq, viol_by_seq;
  logic [PW-1:0] sq_pc, sq_npc;
  logic [CW-1:0] cnt_taken_wrong, cnt_mem_viol;

  exgrp_redirect #(.ISSUE_W(IW), .EXEC_W(EW), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
    .slot_valid(slot_valid), .slot_squashed(slot_squashed),
    .slot_mispred(slot_mispred), .slot_pred_taken(slot_pred_taken),
    .slot_viol(slot_viol), .slot_seq(slot_seq), .slot_pc(slot_pc),
    .slot_npc(slot_npc), .violator_seq(violator_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_npc(sq_npc),
    .sq_mispred(sq_mispred), .sq_taken(sq_taken), .viol_valid(viol_valid),
    .viol_inst_seq(viol_inst_seq), .viol_by_seq(viol_by_seq),
    .cnt_taken_wrong(cnt_taken_wrong), .cnt_mem_viol(cnt_mem_viol)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // expected values
  logic e_valid, e_mp, e_tk, e_vv;
  logic [SW-1:0] e_seq, e_vis, e_vby;
  logic [PW-1:0] e_pc, e_npc;
  int e_ctw = 0, e_cmv = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_slots();
    grp_valid = 1'b0; slot_valid = '0; slot_squashed = '0; slot_mispred = '0;
    slot_pred_taken = '0; slot_viol = '0; slot_seq = '0; slot_pc = '0;
    slot_npc = '0; violator_seq = '0;
  endtask

  task automatic set_slot(input int i, input bit v, input bit sq, input bit mp,
                          input bit pt, input bit vi, input logic [SW-1:0] seq,
                          input logic [PW-1:0] pc, input logic [PW-1:0] npc);
    slot_valid[i] = v; slot_squashed[i] = sq; slot_mispred[i] = mp;
    slot_pred_taken[i] = pt; slot_viol[i] = vi;
    slot_seq[i*SW +: SW] = seq; slot_pc[i*PW +: PW] = pc; slot_npc[i*PW +: PW] = npc;
  endtask

  // Reference model built from the requirements
  task automatic compute_exp();
    bit alive, found, br;
    int used, w;
    alive = 1; found = 0; used = 0; w = 0;
    for (int i = 0; i < IW; i++) begin
      if (!alive || !slot_valid[i] || used >= EW) alive = 0;
      else if (!slot_squashed[i]) begin
        used++;
        if (!found && (slot_mispred[i] || slot_viol[i])) begin found = 1; w = i; end
      end
    end
    e_valid = 0; e_mp = 0; e_tk = 0; e_vv = 0;
    e_seq = '0; e_vis = '0; e_vby = '0; e_pc = '0; e_npc = '0;
    if (grp_valid && found) begin
      br = slot_mispred[w];
      e_valid = 1;
      e_seq = slot_seq[w*SW +: SW];
      e_npc = slot_npc[w*PW +: PW];
      if (br) begin
        e_mp = 1;
        e_pc = slot_pc[w*PW +: PW];
        e_tk = (e_npc != e_pc + 32'd4);
        if (slot_pred_taken[w]) e_ctw++;
      end else begin
        e_vv = 1; e_vis = e_seq; e_vby = violator_seq; e_cmv++;
      end
    end
  endtask

  task automatic check_pkt(input string tag);
    chk(tag, "sq_valid", 64'(sq_valid), 64'(e_valid));
    chk("R7", "sq_seq", 64'(sq_seq), 64'(e_seq));
    chk("R7", "sq_pc", 64'(sq_pc), 64'(e_pc));
    chk("R7", "sq_npc", 64'(sq_npc), 64'(e_npc));
    chk("R7", "sq_mispred", 64'(sq_mispred), 64'(e_mp));
    chk("R8", "sq_taken", 64'(sq_taken), 64'(e_tk));
    chk("R9", "viol_valid", 64'(viol_valid), 64'(e_vv));
    chk("R9", "viol_inst_seq", 64'(viol_inst_seq), 64'(e_vis));
    chk("R9", "viol_by_seq", 64'(viol_by_seq), 64'(e_vby));
    chk("R11", "cnt_taken_wrong", 64'(cnt_taken_wrong), 64'(CW'(e_ctw)));
    chk("R12", "cnt_mem_viol", 64'(cnt_mem_viol), 64'(CW'(e_cmv)));
  endtask

  // Inputs are set at a falling edge; result checked at the next falling edge
  task automatic run_group(input string tag);
    grp_valid = 1'b1;
    compute_exp();
    @(posedge clk); @(negedge clk);
    check_pkt(tag);
  endtask

  // A cycle with slots full of causes but no group: nothing may appear
  task automatic idle_cycle();
    set_slot(0, 1, 0, 1, 1, 1, 8'h77, 32'h100, 32'h200);
    grp_valid = 1'b0;
    compute_exp();
    @(posedge clk); @(negedge clk);
    check_pkt("R10");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R1", "sq_valid in reset", 64'(sq_valid), 64'd0);
    chk("R1", "viol_valid in reset", 64'(viol_valid), 64'd0);
    chk("R1", "cnt_taken_wrong in reset", 64'(cnt_taken_wrong), 64'd0);
    chk("R1", "cnt_mem_viol in reset", 64'(cnt_mem_viol), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_ctw = 0; e_cmv = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_slots();
    #1;
    do_reset();
    // R1: quiet after release
    compute_exp();
    check_pkt("R1");

    // R2: cause after an empty slot is ignored
    clear_slots();
    set_slot(0, 1, 0, 0, 0, 0, 8'h10, 32'h1000, 32'h1004);
    set_slot(2, 1, 0, 1, 1, 0, 8'h12, 32'h1008, 32'h2000);
    run_group("R2");

    // R3: fourth unsquashed slot beyond the unit limit is ignored
    clear_slots();
    set_slot(0, 1, 0, 0, 0, 0, 8'h20, 32'h2000, 32'h2004);
    set_slot(1, 1, 0, 0, 0, 0, 8'h21, 32'h2004, 32'h2008);
    set_slot(2, 1, 0, 0, 0, 0, 8'h22, 32'h2008, 32'h200c);
    set_slot(3, 1, 0, 1, 1, 0, 8'h23, 32'h200c, 32'h3000);
    run_group("R3");

    // R4: squashed slot frees a unit, so slot 3 is reached
    slot_squashed[1] = 1'b1;
    run_group("R4");

    // R4: squashed slot with a mispredict cannot redirect; slot 1 violation wins
    clear_slots();
    set_slot(0, 1, 1, 1, 1, 1, 8'h30, 32'h3000, 32'h4000);
    set_slot(1, 1, 0, 0, 0, 1, 8'h31, 32'h3004, 32'h3008);
    violator_seq = 8'h2c;
    run_group("R4");

    // R5: first cause wins, the later mispredict is ignored
    clear_slots();
    set_slot(0, 1, 0, 0, 0, 0, 8'h40, 32'h4000, 32'h4004);
    set_slot(1, 1, 0, 0, 0, 1, 8'h41, 32'h4004, 32'h4008);
    set_slot(2, 1, 0, 1, 1, 0, 8'h42, 32'h4008, 32'h5000);
    violator_seq = 8'h3f;
    run_group("R5");

    // R6: mispredict beats violation in the same slot
    clear_slots();
    set_slot(0, 1, 0, 1, 0, 1, 8'h50, 32'h5000, 32'h5100);
    violator_seq = 8'h4a;
    run_group("R6");

    // R8: not-taken correction (next PC is the fall-through), predicted taken
    clear_slots();
    set_slot(0, 1, 0, 1, 1, 0, 8'h60, 32'h6000, 32'h6004);
    run_group("R8");
    // R11: not predicted taken, taken correction: counter must not move
    clear_slots();
    set_slot(0, 1, 0, 1, 0, 0, 8'h61, 32'h6010, 32'h7000);
    run_group("R11");

    // R12 and R9: plain memory violation
    clear_slots();
    set_slot(0, 1, 0, 0, 0, 1, 8'h70, 32'h7000, 32'h7004);
    violator_seq = 8'h6e;
    run_group("R12");

    // R10: no group, no packet
    clear_slots();
    idle_cycle();

    // Random groups
    for (int n = 0; n < 400; n++) begin
      clear_slots();
      for (int i = 0; i < IW; i++) begin
        logic [PW-1:0] pc, npc;
        pc  = {$urandom_range(0, 32'h3fff_ffff), 2'b00};
        npc = ($urandom_range(0, 1) == 0) ? pc + 32'd4 : {$urandom_range(0, 32'h3fff_ffff), 2'b00};
        set_slot(i, $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) == 0, SW'($urandom), pc, npc);
      end
      violator_seq = SW'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        grp_valid = 1'b0;
        compute_exp();
        @(posedge clk); @(negedge clk);
        check_pkt("R10");
      end else begin
        run_group("R5");
      end
    end

    // R1: reset mid-run clears counters and packet
    clear_slots();
    do_reset();
    compute_exp();
    check_pkt("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule